// File: doc/BRIEF.md
# Single-Target Prioritised Interrupt Controller with Claim Gating

This block collects level-sensitive interrupt requests from a parameterised set of sources and raises one interrupt line toward a single processor. Every source has a pending bit and a claimed bit. Both are stored in 32-bit words, and source n sits in word n/32 at bit n%32. Each source also has a priority and an enable bit, and a global threshold filters out low-priority work. Arbitration selects one winning source from the pending, enable, priority and threshold state.

Software uses a simple word-addressed register port with single-cycle read and write strobes and no wait states. A read of the claim register hands out the winner and moves it from pending to claimed. A write of a source number to the same register retires that source. While a source is claimed, new requests from it are discarded. The source cannot re-enter arbitration until its completion has been written, so a handler never sees a duplicate of the interrupt it is already servicing. Source number 0 never becomes pending and means "nothing to service".

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, all pending, claimed, enable, priority and threshold state is zero, `irq_o` is low, `cur_claim` is 0 and a claim read returns 0.
- R2: A high request on a source that is neither claimed nor number 0 sets its pending bit on the next clock edge, whether or not the source is enabled. The bit stays set after the request drops. Pending word w reads at word offset 0x40+w, and source n appears in word n/32 at bit n%32.
- R3: The winner is the enabled pending source whose priority is strictly greater than the threshold and highest among such sources. On equal priority the lowest source number wins. If no source qualifies, there is no winner (ID 0).
- R4: `irq_o` is high exactly when a winner exists. It reflects the registered state in the same cycle, with no extra delay.
- R5: A read of the claim register (offset 0x51) returns the winner's ID in `reg_rdata` on the cycle after the strobe. In the same access it clears the winner's pending bit, sets its claimed bit, and loads the ID into `cur_claim`.
- R6: While a source's claimed bit is set, its request does not set its pending bit. The request is dropped, not held for later.
- R7: A write of source ID k to the claim register clears k's claimed bit if it is set. The claimed bits of all other sources are unchanged.
- R8: A completion write whose ID equals `cur_claim` resets `cur_claim` to 0. A completion write with any other ID leaves `cur_claim` unchanged.
- R9: A claim read that returns 0 changes no pending, claimed or `cur_claim` state.
- R10: Source 0 never becomes pending, and its enable bit always reads 0.
- R11: The register map uses word offsets. Priority of source n is at n (read and write). Pending words are at 0x40+w (read only). Enable words are at 0x48+w (read and write). The threshold is at 0x50. Claim and complete share 0x51. Read data is registered and is valid one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Level interrupt requests, one per source |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 7 | Word offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt request to the target |
| cur_claim | output | ID_W | ID of the claim currently held, 0 if none |

## Verification
The hardest situation to reach from the ports is a request that arrives while its source is claimed and must disappear rather than surface after completion. A second hard case is a completion for one of several simultaneously held sources that must release only that source. The stimulus claims three sources one after another, so that tie-breaking and priority order are both visible in the returned IDs. It then retires only one of them and pulses requests on a retired source and a still-held source together. A read of the pending word shows that only the retired source latched. The threshold boundary is reached by making the threshold equal to a pending source's priority and then lowering it by one.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 7;
  localparam logic [6:0]  OFS_PRIO  = 7'h00;
  localparam logic [6:0]  OFS_PEND  = 7'h40;
  localparam logic [6:0]  OFS_EN    = 7'h48;
  localparam logic [6:0]  OFS_THR   = 7'h50;
  localparam logic [6:0]  OFS_CLAIM = 7'h51;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NUM_SRC = 40,
  localparam int unsigned NWORDS = (NUM_SRC + 31) / 32,
  localparam int unsigned FLAT_W = NWORDS * 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] take,
  input  logic [NUM_SRC-1:0] retire,
  output logic [FLAT_W-1:0]  pend_o,
  output logic [FLAT_W-1:0]  held_o
);
  logic [FLAT_W-1:0] req_pad, take_pad, ret_pad, valid_mask;

  always_comb begin
    req_pad    = '0;
    take_pad   = '0;
    ret_pad    = '0;
    valid_mask = '0;
    for (int n = 1; n < NUM_SRC; n++) begin
      req_pad[n]    = req[n];
      take_pad[n]   = take[n];
      ret_pad[n]    = retire[n];
      valid_mask[n] = 1'b1;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [31:0] pend_w, held_w;
    logic [31:0] rq, tk, rt, vm;
    assign rq = req_pad[w*32 +: 32];
    assign tk = take_pad[w*32 +: 32];
    assign rt = ret_pad[w*32 +: 32];
    assign vm = valid_mask[w*32 +: 32];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_w <= '0;
        held_w <= '0;
      end else begin
        pend_w <= (pend_w | (rq & ~held_w & vm)) & ~tk;
        held_w <= (held_w | tk) & ~rt;
      end
    end

    assign pend_o[w*32 +: 32] = pend_w;
    assign held_o[w*32 +: 32] = held_w;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           win_id,
  output logic                      win_valid
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p    = thr;
    win_id    = '0;
    win_valid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && en[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best_p)) begin
        best_p    = prio_flat[i*PRIO_W +: PRIO_W];
        win_id    = ID_W'(i);
        win_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC),
  localparam int unsigned NWORDS = (NUM_SRC + 31) / 32,
  localparam int unsigned FLAT_W = NWORDS * 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [6:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_o,
  output logic [ID_W-1:0]    cur_claim
);
  import prio_irq_pkg::*;

  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [FLAT_W-1:0]         en_q;
  logic [PRIO_W-1:0]         thr_q;
  logic [ID_W-1:0]           held_q;
  logic [31:0]               rdata_q;
  logic [FLAT_W-1:0]         pend_flat, claim_flat;
  logic [ID_W-1:0]           win_id;
  logic                      win_valid;
  logic                      claim_rd, claim_wr, prio_hit;
  logic [NUM_SRC-1:0]        take_vec, retire_vec;

  assign claim_rd = reg_rd && (reg_addr == OFS_CLAIM);
  assign claim_wr = reg_wr && (reg_addr == OFS_CLAIM);
  assign prio_hit = (reg_addr >= OFS_PRIO) && (reg_addr < OFS_PRIO + 7'(NUM_SRC));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
  end

  always_comb begin
    take_vec   = '0;
    retire_vec = '0;
    if (claim_rd && win_valid) take_vec[win_id] = 1'b1;
    if (claim_wr && (reg_wdata < 32'(NUM_SRC))) retire_vec[reg_wdata[ID_W-1:0]] = 1'b1;
  end

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .req    (src_req),
    .take   (take_vec),
    .retire (retire_vec),
    .pend_o (pend_flat),
    .held_o (claim_flat)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend      (pend_flat[NUM_SRC-1:0]),
    .en        (en_q[NUM_SRC-1:0]),
    .prio_flat (prio_flat),
    .thr       (thr_q),
    .win_id    (win_id),
    .win_valid (win_valid)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
      en_q  <= '0;
      thr_q <= '0;
    end else if (reg_wr) begin
      if (prio_hit) prio_q[ID_W'(reg_addr - OFS_PRIO)] <= reg_wdata[PRIO_W-1:0];
      if (reg_addr == OFS_THR) thr_q <= reg_wdata[PRIO_W-1:0];
      for (int w = 0; w < NWORDS; w++) begin
        if (reg_addr == OFS_EN + 7'(w)) begin
          for (int b = 0; b < 32; b++) begin
            en_q[w*32+b] <= ((w*32+b) != 0) && ((w*32+b) < NUM_SRC) && reg_wdata[b];
          end
        end
      end
    end
  end

  // held claim identifier
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else begin
      if (claim_wr && (reg_wdata == 32'(held_q))) held_q <= '0;
      if (claim_rd && win_valid) held_q <= win_id;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (prio_hit) rdata_q <= 32'(prio_q[ID_W'(reg_addr - OFS_PRIO)]);
      if (reg_addr == OFS_THR) rdata_q <= 32'(thr_q);
      if (claim_rd) rdata_q <= 32'(win_id);
      for (int w = 0; w < NWORDS; w++) begin
        if (reg_addr == OFS_PEND + 7'(w)) rdata_q <= pend_flat[w*32 +: 32];
        if (reg_addr == OFS_EN + 7'(w))   rdata_q <= en_q[w*32 +: 32];
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = win_valid;
  assign cur_claim = held_q;
endmodule

// File: rtl/prio_irq_hub_chk.sv
module prio_irq_hub_chk #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ID_W    = 6,
  parameter int unsigned FLAT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [6:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_o,
  input logic [ID_W-1:0]   cur_claim,
  input logic [ID_W-1:0]   win_id,
  input logic [FLAT_W-1:0] pend_flat,
  input logic [FLAT_W-1:0] claim_flat,
  input logic [FLAT_W-1:0] en_q
);
  AST_NO_PEND_WHILE_CLAIMED: assert property (@(posedge clk) disable iff (rst)
    ((pend_flat & ~$past(pend_flat) & $past(claim_flat)) == '0)); // R6

  AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pend_flat[0] == 1'b0 && en_q[0] == 1'b0)); // R10

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend_flat[win_id] && en_q[win_id] && win_id != '0)); // R3

  AST_CLAIM_MOVES: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 7'h51 && irq_o) |=>
      (claim_flat[$past(win_id)] && !pend_flat[$past(win_id)] && cur_claim == $past(win_id))); // R5

  AST_HELD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_rd && reg_addr == 7'h51 && reg_wdata == 32'(cur_claim)) |=> (cur_claim == '0)); // R8

  AST_EMPTY_CLAIM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && reg_addr == 7'h51 && !irq_o) |=> $stable(claim_flat) && $stable(cur_claim)); // R9
endmodule

bind prio_irq_hub prio_irq_hub_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .FLAT_W(FLAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq_o      (irq_o),
  .cur_claim  (cur_claim),
  .win_id     (win_id),
  .pend_flat  (pend_flat),
  .claim_flat (claim_flat),
  .en_q       (en_q)
);

// File: tb/test_prio_irq_hub.sv
module test_prio_irq_hub;
  localparam int unsigned NUM_SRC = 40;
  localparam int unsigned ID_W    = $clog2(NUM_SRC);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] src_req = '0;
  logic               reg_rd = 1'b0, reg_wr = 1'b0;
  logic [6:0]         reg_addr = '0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        reg_rdata;
  logic               irq_o;
  logic [ID_W-1:0]    cur_claim;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  prio_irq_hub #(.NUM_SRC(NUM_SRC), .PRIO_W(3)) i_prio_irq_hub (
    .clk(clk), .rst(rst), .src_req(src_req), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .cur_claim(cur_claim)
  );

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // monitor: read data is compared one cycle after the strobe
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    src_req = v;
    @(negedge clk);
    src_req = '0;
  endtask

  function automatic logic [NUM_SRC-1:0] bitv(input int n);
    logic [NUM_SRC-1:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 cur_claim", 32'(cur_claim), 0);
    rd(7'h40, 0, "R1 pend w0");
    rd(7'h41, 0, "R1 pend w1");
    rd(7'h48, 0, "R1 en w0");
    rd(7'h50, 0, "R1 thr");
    rd(7'h07, 0, "R1 prio7");
    rd(7'h51, 0, "R1 claim");

    // configuration, R11 map
    wr(7'h05, 3); wr(7'h07, 5); wr(7'h21, 3);
    wr(7'h48, 32'hA0); wr(7'h49, 32'h2);
    rd(7'h07, 5, "R11 prio7");
    rd(7'h49, 32'h2, "R11 en w1");

    // R2 R4 R5: single source in the upper word
    pulse(bitv(33));
    rd(7'h41, 32'h2, "R2 pend w1 bit1");
    check("R4 irq up", 32'(irq_o), 1);
    rd(7'h51, 33, "R5 claim 33");
    check("R5 cur_claim", 32'(cur_claim), 33);
    check("R4 irq down", 32'(irq_o), 0);
    rd(7'h41, 0, "R5 pend cleared");

    // R6 request while claimed is dropped
    pulse(bitv(33));
    rd(7'h41, 0, "R6 dropped");
    wr(7'h51, 5);
    check("R8 other id", 32'(cur_claim), 33);
    wr(7'h51, 33);
    check("R8 match", 32'(cur_claim), 0);
    rd(7'h41, 0, "R6 not queued");
    pulse(bitv(33));
    rd(7'h41, 32'h2, "R7 relatched");
    rd(7'h51, 33, "R5 reclaim");
    wr(7'h51, 33);

    // R3 priority and tie order, R9 empty claim
    pulse(bitv(5) | bitv(7) | bitv(33));
    rd(7'h51, 7, "R3 highest prio");
    rd(7'h51, 5, "R3 tie lowest id");
    rd(7'h51, 33, "R3 last");
    rd(7'h51, 0, "R9 empty claim");
    check("R9 cur_claim kept", 32'(cur_claim), 33);
    wr(7'h51, 7);
    check("R8 non-match keeps", 32'(cur_claim), 33);
    pulse(bitv(5) | bitv(7));
    rd(7'h40, 32'h80, "R7 only retired relatches");
    rd(7'h51, 7, "R7 claim 7");
    wr(7'h51, 5); wr(7'h51, 7); wr(7'h51, 33);
    check("R8 cleared", 32'(cur_claim), 0);

    // R3 threshold is strict, R9 keeps pending
    wr(7'h50, 3);
    pulse(bitv(5));
    check("R3 at threshold", 32'(irq_o), 0);
    rd(7'h51, 0, "R9 claim none");
    rd(7'h40, 32'h20, "R9 pend kept");
    wr(7'h50, 2);
    check("R3 above threshold", 32'(irq_o), 1);
    rd(7'h51, 5, "R3 claim 5");
    wr(7'h51, 5);
    wr(7'h50, 0);

    // R2 pending without enable, R3 disabled source ignored
    pulse(bitv(9));
    rd(7'h40, 32'h200, "R2 pend unenabled");
    check("R3 disabled no irq", 32'(irq_o), 0);
    wr(7'h09, 1); wr(7'h48, 32'h2A0);
    check("R4 enabled irq", 32'(irq_o), 1);
    rd(7'h51, 9, "R5 claim 9");
    wr(7'h51, 9);

    // R10 source 0
    pulse(bitv(0));
    rd(7'h40, 0, "R10 src0 pend");
    wr(7'h48, 32'h2A1);
    rd(7'h48, 32'h2A0, "R10 src0 enable");
    check("R10 irq", 32'(irq_o), 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule